// File: doc/BRIEF.md
# Tagged-Token Operand Matching Stage

This block is the middle of a tagged-token dataflow pipeline. A token carries a frame pointer, an instruction pointer, a port bit and a data value. Tokens enter through two input queues, one for system traffic and one for user traffic. One token per cycle leaves the queues, and the system queue is served first. The block fetches the instruction that the token's instruction pointer names. The instruction picks an addressing mode and a waiting-matching rule. These decide how the token meets its partner operand in a small frame store that carries one presence bit per slot.

When an instruction fires, its two operands go through a small ALU. The result is then spread over zero, one or two output tokens. Each output token uses the destination tags held in the instruction. A condition bit taken from the right operand can steer the result to only one of the two destinations, which gives switch-style routing. No hazard logic is needed. Frame read, presence test and update all happen in one stage, so the next token sees the updated slot.

Top module: `dfm_match_top`

## Requirements
- R1: After reset both output valids are low, both queues are empty and ready, every presence bit is clear and every frame value is zero.
- R2: The instruction word, MSB to LSB, is: alu_op[2:0], abs[0], wm[2:0], r[3:0], d1_ip[3:0], d1_port, d2_en, d2_ip[3:0], d2_port, sw. A token word, MSB to LSB, is fp[3:0], ip[3:0], port, val[15:0]. Instructions are loaded through the write port and fetched by the token's ip.
- R3: Each queue is FIFO with depth QDEPTH. A non-empty system queue is always popped before the user queue. The ready output of a queue is low when it is full, and a push while full is dropped.
- R4: The effective slot is r when abs=1. Otherwise it is (fp + r) mod 16.
- R5: Unary (wm=0) fires at once with left operand = token value and right operand = 0. The frame store is not touched.
- R6: Normal (wm=1): if the slot has no presence bit, the value is stored, presence is set and nothing fires. Otherwise the instruction fires with the stored partner and clears presence.
- R7: Sticky (wm=2) behaves like normal, except that on a match the stored value and its presence bit are kept.
- R8: Exchange (wm=3) stores the incoming value in every case and sets presence. On a match it fires with the value that was stored before.
- R9: Imperative (wm=4) always fires with the stored value, whatever the presence bit, and leaves the slot unchanged. The codes wm=5..7 act as unary.
- R10: For matching rules, a token on port 0 is the left operand and the stored partner is the right operand. A token on port 1 is the right operand.
- R11: The ALU ops are 0 add, 1 sub (left-right), 2 and, 3 or, 4 xor, 5 pass left, 6 unsigned left<right giving 1 or 0, and 7 equal giving 1 or 0.
- R12: Output A carries tag (fp, d1_ip, d1_port). Output B carries tag (fp, d2_ip, d2_port) and needs d2_en. Both carry the result. With sw=1 and cc = (right operand != 0), A is sent only when cc=1 and B only when cc=0.
- R13: A token pushed into an idle block gives its outputs three clock edges after the push edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| im_we_i | input | 1 | Instruction memory write enable |
| im_addr_i | input | 4 | Instruction memory write address |
| im_wdata_i | input | 23 | Instruction word |
| sys_valid_i | input | 1 | Push into the system queue |
| sys_tok_i | input | 25 | System token |
| sys_ready_o | output | 1 | System queue not full |
| usr_valid_i | input | 1 | Push into the user queue |
| usr_tok_i | input | 25 | User token |
| usr_ready_o | output | 1 | User queue not full |
| out_a_valid_o | output | 1 | First destination token valid |
| out_a_tok_o | output | 25 | First destination token |
| out_b_valid_o | output | 1 | Second destination token valid |
| out_b_tok_o | output | 25 | Second destination token |

## Verification
The key collision is a user push that arrives in the same cycle as a system push and a system pop. The bench holds both inputs active for several cycles in a row. The user queue starves behind the system stream, fills, drops a push while its ready is low, and then drains in order once the system stream stops. A behavioural model with two list queues and a three-slot delay line predicts every output on every cycle. This covers which token leaves when, and which user token was lost.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
  parameter int VAL_W = 16;
  parameter int IP_W  = 4;
  parameter int FA_W  = 4;
  localparam int IMD  = 1 << IP_W;
  localparam int FMD  = 1 << FA_W;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASSL, ALU_LTU, ALU_EQ
  } alu_op_e;

  typedef enum logic [2:0] {
    WM_UNARY, WM_NORMAL, WM_STICKY, WM_EXCH, WM_IMPER
  } wm_e;

  typedef struct packed {
    logic [FA_W-1:0]  fp;
    logic [IP_W-1:0]  ip;
    logic             port;
    logic [VAL_W-1:0] val;
  } tok_t;

  typedef struct packed {
    alu_op_e         op;
    logic            ea_abs;
    wm_e             wm;
    logic [FA_W-1:0] r;
    logic [IP_W-1:0] d1_ip;
    logic            d1_port;
    logic            d2_en;
    logic [IP_W-1:0] d2_ip;
    logic            d2_port;
    logic            sw;
  } instr_t;

  localparam int TOK_W   = $bits(tok_t);
  localparam int INSTR_W = $bits(instr_t);

  typedef struct packed {
    logic   vld;
    tok_t   tok;
    instr_t ins;
  } s1_t;

  typedef struct packed {
    logic             vld;
    logic [FA_W-1:0]  fp;
    instr_t           ins;
    logic [VAL_W-1:0] vl;
    logic [VAL_W-1:0] vr;
  } s2_t;
endpackage

// File: rtl/dfm_tok_fifo.sv
module dfm_tok_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [W-1:0]       din_i,
  input  logic               pop_i,
  output logic [W-1:0]       dout_o,
  output logic               empty_o,
  output logic               full_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rp];
  assign count_o = cnt;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/dfm_match_unit.sv
module dfm_match_unit import dfm_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  s1_t             s1_i,
  output s2_t             s2_o,
  output logic [FMD-1:0]  pres_o,
  output logic [FA_W-1:0] ea_o
);
  logic [VAL_W-1:0] fval [FMD];
  logic [FMD-1:0]   pres;
  logic [FA_W-1:0]  ea;
  logic             pb, fire, wr, set_pb, clr_pb;
  logic [VAL_W-1:0] stored, partner, vl, vr;

  assign ea     = s1_i.ins.ea_abs ? s1_i.ins.r : s1_i.tok.fp + s1_i.ins.r;
  assign pb     = pres[ea];
  assign stored = fval[ea];
  assign pres_o = pres;
  assign ea_o   = ea;

  always_comb begin
    fire    = 1'b0;
    wr      = 1'b0;
    set_pb  = 1'b0;
    clr_pb  = 1'b0;
    partner = stored;
    unique case (s1_i.ins.wm)
      WM_NORMAL: begin
        fire = pb;
        if (pb) clr_pb = 1'b1;
        else begin wr = 1'b1; set_pb = 1'b1; end
      end
      WM_STICKY: begin
        fire = pb;
        if (!pb) begin wr = 1'b1; set_pb = 1'b1; end
      end
      WM_EXCH: begin
        fire   = pb;
        wr     = 1'b1;
        set_pb = 1'b1;
      end
      WM_IMPER: fire = 1'b1;
      default: begin
        fire    = 1'b1;
        partner = '0;
      end
    endcase
    if (s1_i.ins.wm inside {WM_NORMAL, WM_STICKY, WM_EXCH, WM_IMPER} && s1_i.tok.port) begin
      vl = partner;
      vr = s1_i.tok.val;
    end else begin
      vl = s1_i.tok.val;
      vr = partner;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pres <= '0;
      s2_o <= '0;
      for (int i = 0; i < FMD; i++) fval[i] <= '0;
    end else begin
      if (s1_i.vld) begin
        if (wr)     fval[ea] <= s1_i.tok.val;
        if (set_pb) pres[ea] <= 1'b1;
        if (clr_pb) pres[ea] <= 1'b0;
      end
      s2_o.vld <= s1_i.vld && fire;
      s2_o.fp  <= s1_i.tok.fp;
      s2_o.ins <= s1_i.ins;
      s2_o.vl  <= vl;
      s2_o.vr  <= vr;
    end
  end
endmodule

// File: rtl/dfm_alu_form.sv
module dfm_alu_form import dfm_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  s2_t  s2_i,
  output logic a_vld_o,
  output tok_t a_tok_o,
  output logic b_vld_o,
  output tok_t b_tok_o
);
  logic [VAL_W-1:0] res;
  logic             cc, en_a, en_b;

  always_comb begin
    unique case (s2_i.ins.op)
      ALU_ADD:   res = s2_i.vl + s2_i.vr;
      ALU_SUB:   res = s2_i.vl - s2_i.vr;
      ALU_AND:   res = s2_i.vl & s2_i.vr;
      ALU_OR:    res = s2_i.vl | s2_i.vr;
      ALU_XOR:   res = s2_i.vl ^ s2_i.vr;
      ALU_PASSL: res = s2_i.vl;
      ALU_LTU:   res = VAL_W'(s2_i.vl < s2_i.vr);
      default:   res = VAL_W'(s2_i.vl == s2_i.vr);
    endcase
  end

  assign cc   = |s2_i.vr;
  assign en_a = s2_i.vld && (!s2_i.ins.sw || cc);
  assign en_b = s2_i.vld && s2_i.ins.d2_en && (!s2_i.ins.sw || !cc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_o <= 1'b0;
      b_vld_o <= 1'b0;
      a_tok_o <= '0;
      b_tok_o <= '0;
    end else begin
      a_vld_o <= en_a;
      b_vld_o <= en_b;
      a_tok_o <= '{fp: s2_i.fp, ip: s2_i.ins.d1_ip, port: s2_i.ins.d1_port, val: res};
      b_tok_o <= '{fp: s2_i.fp, ip: s2_i.ins.d2_ip, port: s2_i.ins.d2_port, val: res};
    end
  end
endmodule

// File: rtl/dfm_match_top.sv
module dfm_match_top import dfm_pkg::*; #(
  parameter int QDEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               im_we_i,
  input  logic [IP_W-1:0]    im_addr_i,
  input  logic [INSTR_W-1:0] im_wdata_i,
  input  logic               sys_valid_i,
  input  logic [TOK_W-1:0]   sys_tok_i,
  output logic               sys_ready_o,
  input  logic               usr_valid_i,
  input  logic [TOK_W-1:0]   usr_tok_i,
  output logic               usr_ready_o,
  output logic               out_a_valid_o,
  output logic [TOK_W-1:0]   out_a_tok_o,
  output logic               out_b_valid_o,
  output logic [TOK_W-1:0]   out_b_tok_o
);
  localparam int CW = $clog2(QDEPTH+1);

  logic [TOK_W-1:0] sys_head, usr_head;
  logic             sys_empty, usr_empty, sys_full, usr_full;
  logic [CW-1:0]    sys_cnt, usr_cnt;
  logic             pop_sys, pop_usr;
  tok_t             head;
  instr_t           imem [IMD];
  s1_t              s1_q;
  s2_t              s2_q;
  logic [FMD-1:0]   pres;
  logic [FA_W-1:0]  ea;
  tok_t             a_tok, b_tok;

  dfm_tok_fifo #(.W(TOK_W), .DEPTH(QDEPTH)) u_sys_q (
    .clk_i, .rst_ni, .push_i(sys_valid_i), .din_i(sys_tok_i), .pop_i(pop_sys),
    .dout_o(sys_head), .empty_o(sys_empty), .full_o(sys_full), .count_o(sys_cnt));

  dfm_tok_fifo #(.W(TOK_W), .DEPTH(QDEPTH)) u_usr_q (
    .clk_i, .rst_ni, .push_i(usr_valid_i), .din_i(usr_tok_i), .pop_i(pop_usr),
    .dout_o(usr_head), .empty_o(usr_empty), .full_o(usr_full), .count_o(usr_cnt));

  assign sys_ready_o = !sys_full;
  assign usr_ready_o = !usr_full;
  assign pop_sys     = !sys_empty;
  assign pop_usr     = sys_empty && !usr_empty;
  assign head        = pop_sys ? tok_t'(sys_head) : tok_t'(usr_head);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < IMD; i++) imem[i] <= '0;
      s1_q <= '0;
    end else begin
      if (im_we_i) imem[im_addr_i] <= instr_t'(im_wdata_i);
      s1_q.vld <= pop_sys || pop_usr;
      s1_q.tok <= head;
      s1_q.ins <= imem[head.ip];
    end
  end

  dfm_match_unit u_match (
    .clk_i, .rst_ni, .s1_i(s1_q), .s2_o(s2_q), .pres_o(pres), .ea_o(ea));

  dfm_alu_form u_form (
    .clk_i, .rst_ni, .s2_i(s2_q),
    .a_vld_o(out_a_valid_o), .a_tok_o(a_tok),
    .b_vld_o(out_b_valid_o), .b_tok_o(b_tok));

  assign out_a_tok_o = a_tok;
  assign out_b_tok_o = b_tok;
endmodule

// File: rtl/dfm_match_chk.sv
module dfm_match_chk import dfm_pkg::*; #(
  parameter int QDEPTH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [$clog2(QDEPTH+1)-1:0] sys_cnt,
  input logic [$clog2(QDEPTH+1)-1:0] usr_cnt,
  input logic                       pop_sys,
  input logic                       pop_usr,
  input s1_t                        s1_q,
  input s2_t                        s2_q,
  input logic [FMD-1:0]             pres,
  input logic [FA_W-1:0]            ea,
  input logic                       out_a_valid_o,
  input logic                       out_b_valid_o
);
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_cnt <= QDEPTH) && (usr_cnt <= QDEPTH));

  p_pop_fills_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_sys || pop_usr) |=> s1_q.vld);

  p_unary_fire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_q.vld && s1_q.ins.wm == WM_UNARY) |=> s2_q.vld);

  p_normal_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_q.vld && s1_q.ins.wm == WM_NORMAL && pres[ea]) |=> !pres[$past(ea)]);

  p_sticky_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_q.vld && s1_q.ins.wm == WM_STICKY) |=> pres[$past(ea)]);

  p_exch_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_q.vld && s1_q.ins.wm == WM_EXCH) |=> pres[$past(ea)]);

  p_out_src_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_a_valid_o || out_b_valid_o) |-> $past(s2_q.vld));
endmodule

bind dfm_match_top dfm_match_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_cnt(sys_cnt), .usr_cnt(usr_cnt),
  .pop_sys(pop_sys), .pop_usr(pop_usr), .s1_q(s1_q), .s2_q(s2_q),
  .pres(pres), .ea(ea), .out_a_valid_o(out_a_valid_o), .out_b_valid_o(out_b_valid_o));

// File: tb/dfm_match_top_tb.sv
module dfm_match_top_tb_top;
  import dfm_pkg::*;
  localparam int QD = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic im_we_i = 1'b0;
  logic [IP_W-1:0] im_addr_i = '0;
  logic [INSTR_W-1:0] im_wdata_i = '0;
  logic sys_valid_i = 1'b0, usr_valid_i = 1'b0;
  logic [TOK_W-1:0] sys_tok_i = '0, usr_tok_i = '0;
  logic sys_ready_o, usr_ready_o, out_a_valid_o, out_b_valid_o;
  logic [TOK_W-1:0] out_a_tok_o, out_b_tok_o;

  always #5 clk_i = ~clk_i;

  dfm_match_top #(.QDEPTH(QD)) dut_i (.*);

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit run_cmp = 1'b0;

  // reference model state
  tok_t   sysq[$], usrq[$];
  instr_t im[IMD];
  logic [VAL_W-1:0] fv[FMD];
  bit     fpb[FMD];
  bit     m1_v, m2_v, ma_v, mb_v;
  tok_t   m1_t, ma_t, mb_t;
  instr_t m1_i, m2_i;
  logic [FA_W-1:0]  m2_fp;
  logic [VAL_W-1:0] m2_l, m2_r;

  initial begin
    for (int i = 0; i < IMD; i++) im[i] = '0;
    for (int i = 0; i < FMD; i++) begin fv[i] = '0; fpb[i] = 1'b0; end
    m1_v = 0; m2_v = 0; ma_v = 0; mb_v = 0;
    m1_t = '0; ma_t = '0; mb_t = '0; m1_i = '0; m2_i = '0; m2_fp = '0; m2_l = '0; m2_r = '0;
  end

  always @(posedge clk_i) if (rst_ni) begin
    logic [VAL_W-1:0] res, part, v;
    logic [FA_W-1:0] a;
    bit fire, cc, sfull, ufull;
    // output stage
    case (m2_i.op)
      ALU_ADD: res = m2_l + m2_r;
      ALU_SUB: res = m2_l - m2_r;
      ALU_AND: res = m2_l & m2_r;
      ALU_OR:  res = m2_l | m2_r;
      ALU_XOR: res = m2_l ^ m2_r;
      ALU_PASSL: res = m2_l;
      ALU_LTU: res = (m2_l < m2_r) ? 1 : 0;
      default: res = (m2_l == m2_r) ? 1 : 0;
    endcase
    cc = (m2_r != 0);
    ma_v = m2_v && (!m2_i.sw || cc);
    mb_v = m2_v && m2_i.d2_en && (!m2_i.sw || !cc);
    ma_t = '{fp: m2_fp, ip: m2_i.d1_ip, port: m2_i.d1_port, val: res};
    mb_t = '{fp: m2_fp, ip: m2_i.d2_ip, port: m2_i.d2_port, val: res};
    // matching stage
    m2_v = 0;
    if (m1_v) begin
      a = m1_i.ea_abs ? m1_i.r : m1_t.fp + m1_i.r;
      v = m1_t.val; part = fv[a]; fire = 1;
      case (m1_i.wm)
        WM_NORMAL: begin fire = fpb[a]; if (fpb[a]) fpb[a] = 0; else begin fv[a] = v; fpb[a] = 1; end end
        WM_STICKY: begin fire = fpb[a]; if (!fpb[a]) begin fv[a] = v; fpb[a] = 1; end end
        WM_EXCH:   begin fire = fpb[a]; fv[a] = v; fpb[a] = 1; end
        WM_IMPER:  fire = 1;
        default:   part = 0;
      endcase
      m2_v = fire; m2_fp = m1_t.fp; m2_i = m1_i;
      if (m1_i.wm inside {WM_NORMAL, WM_STICKY, WM_EXCH, WM_IMPER} && m1_t.port) begin
        m2_l = part; m2_r = v;
      end else begin
        m2_l = v; m2_r = part;
      end
    end
    // queue pop
    sfull = (sysq.size() >= QD);
    ufull = (usrq.size() >= QD);
    m1_v = 1;
    if (sysq.size() > 0) m1_t = sysq.pop_front();
    else if (usrq.size() > 0) m1_t = usrq.pop_front();
    else m1_v = 0;
    m1_i = im[m1_t.ip];
    if (sys_valid_i && !sfull) sysq.push_back(tok_t'(sys_tok_i));
    if (usr_valid_i && !ufull) usrq.push_back(tok_t'(usr_tok_i));
    if (im_we_i) im[im_addr_i] = instr_t'(im_wdata_i);
  end

  task automatic chk(input bit ok, input string what, input logic [TOK_W-1:0] act, input logic [TOK_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (run_cmp) begin
    chk(out_a_valid_o == ma_v && (!ma_v || out_a_tok_o == ma_t), "out_a",
        {out_a_valid_o, out_a_tok_o}, {ma_v, ma_t});
    chk(out_b_valid_o == mb_v && (!mb_v || out_b_tok_o == mb_t), "out_b",
        {out_b_valid_o, out_b_tok_o}, {mb_v, mb_t});
    chk(sys_ready_o == (sysq.size() < QD) && usr_ready_o == (usrq.size() < QD), "ready",
        TOK_W'({sys_ready_o, usr_ready_o}), TOK_W'({sysq.size() < QD, usrq.size() < QD}));
  end

  function automatic logic [INSTR_W-1:0] mk(input int op, abs_m, wm, r, d1, p1, e2, d2, p2, sw);
    instr_t x;
    x = '{op: alu_op_e'(op), ea_abs: abs_m[0], wm: wm_e'(wm), r: r[FA_W-1:0],
          d1_ip: d1[IP_W-1:0], d1_port: p1[0], d2_en: e2[0], d2_ip: d2[IP_W-1:0],
          d2_port: p2[0], sw: sw[0]};
    return x;
  endfunction

  function automatic logic [TOK_W-1:0] tk(input int fp, ip, port, val);
    tok_t t;
    t = '{fp: fp[FA_W-1:0], ip: ip[IP_W-1:0], port: port[0], val: val[VAL_W-1:0]};
    return t;
  endfunction

  task automatic load(input int addr, input logic [INSTR_W-1:0] w);
    im_we_i = 1; im_addr_i = addr[IP_W-1:0]; im_wdata_i = w;
    @(posedge clk_i); #1 im_we_i = 0;
  endtask

  task automatic put(input bit sys, input logic [TOK_W-1:0] t);
    if (sys) begin sys_valid_i = 1; sys_tok_i = t; end
    else begin usr_valid_i = 1; usr_tok_i = t; end
    @(posedge clk_i); #1 sys_valid_i = 0; usr_valid_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    run_cmp = 1;
    cur_req = "R1"; idle(2);
    // program load, R2
    cur_req = "R2";
    load(0, mk(ALU_PASSL, 0, WM_UNARY, 0, 1, 0, 0, 0, 0, 0));
    load(1, mk(ALU_SUB,   0, WM_NORMAL, 2, 3, 1, 1, 4, 0, 0));
    load(2, mk(ALU_ADD,   1, WM_STICKY, 5, 6, 0, 0, 0, 0, 0));
    load(3, mk(ALU_XOR,   0, WM_EXCH, 1, 7, 1, 1, 8, 1, 0));
    load(4, mk(ALU_OR,    1, WM_IMPER, 5, 9, 0, 0, 0, 0, 0));
    load(5, mk(ALU_PASSL, 0, WM_NORMAL, 0, 10, 0, 1, 11, 1, 1));
    load(6, mk(ALU_AND,   1, WM_IMPER, 5, 12, 0, 0, 0, 0, 0));
    load(7, mk(ALU_LTU,   1, WM_IMPER, 5, 13, 1, 1, 2, 0, 0));
    load(8, mk(ALU_EQ,    1, WM_IMPER, 5, 14, 0, 0, 0, 0, 0));
    load(9, mk(ALU_ADD,   0, WM_UNARY, 0, 1, 1, 1, 2, 1, 1));
    load(10, mk(ALU_SUB,  0, 6, 0, 3, 0, 1, 5, 0, 0));
    cur_req = "R13"; put(0, tk(2, 0, 0, 16'h1234)); idle(5);
    cur_req = "R5";  put(1, tk(3, 0, 1, 16'h0042)); put(0, tk(1, 9, 0, 16'h0007)); idle(5);
    cur_req = "R6";  put(0, tk(4, 1, 0, 100)); idle(2); put(0, tk(4, 1, 1, 30)); idle(4);
    cur_req = "R10"; put(0, tk(15, 1, 1, 30)); put(0, tk(15, 1, 0, 100)); idle(4);
    cur_req = "R4";  put(0, tk(14, 1, 0, 9)); put(0, tk(0, 1, 1, 4)); idle(4);
    cur_req = "R7";  put(0, tk(0, 2, 0, 1000)); put(0, tk(3, 2, 1, 5)); put(0, tk(9, 2, 0, 6)); idle(4);
    cur_req = "R9";  put(0, tk(0, 4, 0, 16'h00f0)); put(0, tk(0, 6, 1, 16'h0f0f)); idle(4);
    cur_req = "R11"; put(0, tk(0, 7, 0, 3)); put(0, tk(0, 7, 1, 3)); put(0, tk(0, 8, 0, 1000)); idle(4);
    cur_req = "R8";  put(0, tk(6, 3, 0, 16'haaaa)); put(0, tk(6, 3, 1, 16'h5555)); put(0, tk(6, 3, 0, 16'h0f0f)); idle(4);
    cur_req = "R12"; put(0, tk(2, 5, 0, 77)); put(0, tk(2, 5, 1, 1));
                     put(0, tk(2, 5, 0, 88)); put(0, tk(2, 5, 1, 0)); idle(4);
    cur_req = "R9";  put(0, tk(5, 10, 0, 12)); idle(4);
    // R3: system stream starves the user queue until it fills
    cur_req = "R3";
    for (int i = 0; i < 7; i++) begin
      sys_valid_i = 1; sys_tok_i = tk(1, 0, 0, 16'h5000 + i);
      usr_valid_i = 1; usr_tok_i = tk(2, 0, 0, 16'h6000 + i);
      @(posedge clk_i); #1;
    end
    sys_valid_i = 0; usr_valid_i = 0;
    idle(10);
    cur_req = "R1";
    rst_ni = 0; #1;
    chk(!out_a_valid_o && !out_b_valid_o && sys_ready_o && usr_ready_o, "reset outputs",
        TOK_W'({out_a_valid_o, out_b_valid_o}), '0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule